// File: doc/BRIEF.md
# Software Store/Recall Sequence Controller

This block sits in front of a nonvolatile SRAM model and decides when the contents are copied between the volatile array and its nonvolatile shadow. It needs no dedicated control pin. Instead it watches ordinary read cycles, each framed by chip enable, for a fixed "knock" of six addresses. The first five addresses are fixed. The sixth address selects the operation: a STORE copies the SRAM into the nonvolatile cells, and a RECALL copies the nonvolatile cells back into the SRAM. A write, a stray address, a repeated read or a low supply breaks the knock, and detection starts again from the first address.

Once an operation begins, it runs for a parameterised number of clock cycles. During that time `busy` is held high and every bus input is ignored. A low supply aborts a STORE, but a RECALL always runs to the end. A rising supply-good input starts an automatic RECALL, which covers power-up. Single-cycle pulses mark the start, the completion and the abort of each operation.

Top module: `sr_seq_ctrl`

## Requirements
- R1: While `rst_n` is low and right after it is released, `busy`, `store_start`, `recall_start`, `op_done` and `op_aborted` are all 0, and the knock sequence is empty.
- R2: A read is counted only in a cycle where `ce_n` is 0, `ce_n` was 1 in the previous cycle, and `we_n` is 1. Holding `ce_n` low over several cycles counts as a single read, even if `addr` changes.
- R3: `oe_n` has no influence on sequence detection or on any output.
- R4: Any cycle with both `ce_n` and `we_n` low clears the sequence back to empty.
- R5: The sequence consists of reads at PREFIX entries 0 to 4, in that order (defaults 0x0A55, 0x15AA, 0x0333, 0x1CCC, 0x00FF), followed by a sixth read. If the sixth address is STORE_CODE (default 0x1F00), `store_start` pulses in the cycle after that read. If it is RECALL_CODE (default 0x0E0E), `recall_start` pulses instead.
- R6: A read at an address other than the next expected one empties the sequence. If that address equals PREFIX entry 0, it counts as the first step instead. This means a repeated read of the same address breaks the sequence. A sixth address that is neither code starts nothing.
- R7: `busy` rises together with the start pulse and stays high for exactly STORE_CYCLES cycles (STORE) or RECALL_CYCLES cycles (RECALL). `op_done` then pulses for one cycle as `busy` falls.
- R8: While `busy` is high, `ce_n`, `we_n` and `addr` are ignored, and no partial sequence survives the operation.
- R9: During a STORE, a busy cycle with `vcc_ok` low makes `busy` fall in the next cycle, with an `op_aborted` pulse and no `op_done`.
- R10: A RECALL is never aborted; `vcc_ok` low during a RECALL has no effect.
- R11: When idle, a 0-to-1 change of `vcc_ok` (including `vcc_ok` already high when reset is released) starts a RECALL in the next cycle. While `vcc_ok` is low, reads are not counted and the sequence is cleared.
- R12: At most one of `store_start`, `recall_start`, `op_done`, `op_aborted` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low; its falling edge frames a read |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low; ignored by the sequencer |
| addr | input | ADDR_W | Bus address |
| vcc_ok | input | 1 | Supply above the switch threshold |
| busy | output | 1 | STORE or RECALL in progress |
| store_start | output | 1 | One-cycle pulse when a STORE begins |
| recall_start | output | 1 | One-cycle pulse when a RECALL begins |
| op_done | output | 1 | One-cycle pulse when an operation completes |
| op_aborted | output | 1 | One-cycle pulse when a STORE is cut short |

## Verification
The hardest states to reach are the ones where a nearly complete knock meets an interruption. Examples are a repeated read one step before the end, a write inside the sequence, a chip enable held low across several address changes, and a complete knock issued while an operation is still busy. The stimulus builds each of these from two-cycle read and write tasks. It lowers the supply in the middle of both a STORE and a RECALL. A behavioural model tracks the expected step and remaining cycles, so each broken knock is followed by checks that no pulse appeared and that the next clean knock still works.

// File: rtl/sr_seq_pkg.sv
package sr_seq_pkg;

  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_STORE  = 2'd1,
    OP_RECALL = 2'd2
  } opState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic seqClr;
    logic seqAdv;
    logic seqRestart;
    logic loadStore;
    logic loadRecall;
    logic cntDec;
  } seqStrobe_t;

  // Conditions from datapath to control
  typedef struct packed {
    logic rdEvt;
    logic wrEvt;
    logic vccRise;
    logic addrIsNext;
    logic addrIsFirst;
    logic atFinal;
    logic isStoreCode;
    logic isRecallCode;
    logic cntZero;
  } seqStatus_t;

endpackage

// File: rtl/sr_seq_dp.sv
module sr_seq_dp
  import sr_seq_pkg::*;
#(
  parameter int ADDR_W        = 13,
  parameter int SEQ_LEN       = 6,
  parameter logic [(SEQ_LEN-1)*ADDR_W-1:0] PREFIX = '0,
  parameter logic [ADDR_W-1:0] STORE_CODE  = '0,
  parameter logic [ADDR_W-1:0] RECALL_CODE = '0,
  parameter int STORE_CYCLES  = 500000,
  parameter int RECALL_CYCLES = 1000,
  localparam int STEP_W  = $clog2(SEQ_LEN),
  localparam int CNT_MAX = (STORE_CYCLES > RECALL_CYCLES) ? STORE_CYCLES : RECALL_CYCLES,
  localparam int CNT_W   = $clog2(CNT_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ceN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              vccOk,
  input  seqStrobe_t        stb,
  output seqStatus_t        stat,
  output logic [STEP_W-1:0] seqStep
);

  logic             cePrev;
  logic             vccPrev;
  logic [CNT_W-1:0] cnt;
  logic [SEQ_LEN-2:0] hitVec;

  // One comparator per prefix position, enabled only at its own step
  for (genvar g = 0; g < SEQ_LEN - 1; g++) begin : gKey
    assign hitVec[g] = (seqStep == STEP_W'(g)) &&
                       (addr == PREFIX[g*ADDR_W +: ADDR_W]);
  end

  always_comb begin
    stat.rdEvt        = cePrev && !ceN && weN;
    stat.wrEvt        = !ceN && !weN;
    stat.vccRise      = vccOk && !vccPrev;
    stat.addrIsNext   = |hitVec;
    stat.addrIsFirst  = (addr == PREFIX[ADDR_W-1:0]);
    stat.atFinal      = (seqStep == STEP_W'(SEQ_LEN - 1));
    stat.isStoreCode  = (addr == STORE_CODE);
    stat.isRecallCode = (addr == RECALL_CODE);
    stat.cntZero      = (cnt == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cePrev  <= 1'b1;
      vccPrev <= 1'b0;
      seqStep <= '0;
      cnt     <= '0;
    end else begin
      cePrev  <= ceN;
      vccPrev <= vccOk;
      if (stb.seqClr)          seqStep <= '0;
      else if (stb.seqRestart) seqStep <= STEP_W'(1);
      else if (stb.seqAdv)     seqStep <= seqStep + STEP_W'(1);
      if (stb.loadStore)       cnt <= CNT_W'(STORE_CYCLES - 1);
      else if (stb.loadRecall) cnt <= CNT_W'(RECALL_CYCLES - 1);
      else if (stb.cntDec)     cnt <= cnt - CNT_W'(1);
    end
  end

endmodule

// File: rtl/sr_seq_fsm.sv
module sr_seq_fsm
  import sr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vccOk,
  input  seqStatus_t stat,
  output seqStrobe_t stb,
  output logic       busy,
  output logic       storeStart,
  output logic       recallStart,
  output logic       opDone,
  output logic       opAborted
);

  opState_e state, nxt;
  logic goStore, goRecall, fin, abt;

  always_comb begin
    stb      = '0;
    nxt      = state;
    goStore  = 1'b0;
    goRecall = 1'b0;
    fin      = 1'b0;
    abt      = 1'b0;
    unique case (state)
      OP_IDLE: begin
        if (stat.vccRise) begin
          stb.seqClr = 1'b1; stb.loadRecall = 1'b1;
          goRecall = 1'b1; nxt = OP_RECALL;
        end else if (!vccOk || stat.wrEvt) begin
          stb.seqClr = 1'b1;
        end else if (stat.rdEvt) begin
          if (stat.atFinal) begin
            if (stat.isStoreCode) begin
              stb.seqClr = 1'b1; stb.loadStore = 1'b1;
              goStore = 1'b1; nxt = OP_STORE;
            end else if (stat.isRecallCode) begin
              stb.seqClr = 1'b1; stb.loadRecall = 1'b1;
              goRecall = 1'b1; nxt = OP_RECALL;
            end else if (stat.addrIsFirst) begin
              stb.seqRestart = 1'b1;
            end else begin
              stb.seqClr = 1'b1;
            end
          end else if (stat.addrIsNext) begin
            stb.seqAdv = 1'b1;
          end else if (stat.addrIsFirst) begin
            stb.seqRestart = 1'b1;
          end else begin
            stb.seqClr = 1'b1;
          end
        end
      end
      OP_STORE: begin
        stb.seqClr = 1'b1;
        if (!vccOk) begin
          abt = 1'b1; nxt = OP_IDLE;
        end else if (stat.cntZero) begin
          fin = 1'b1; nxt = OP_IDLE;
        end else begin
          stb.cntDec = 1'b1;
        end
      end
      OP_RECALL: begin
        stb.seqClr = 1'b1;
        if (stat.cntZero) begin
          fin = 1'b1; nxt = OP_IDLE;
        end else begin
          stb.cntDec = 1'b1;
        end
      end
      default: nxt = OP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= OP_IDLE;
      storeStart  <= 1'b0;
      recallStart <= 1'b0;
      opDone      <= 1'b0;
      opAborted   <= 1'b0;
    end else begin
      state       <= nxt;
      storeStart  <= goStore;
      recallStart <= goRecall;
      opDone      <= fin;
      opAborted   <= abt;
    end
  end

  assign busy = (state != OP_IDLE);

endmodule

// File: rtl/sr_seq_ctrl.sv
module sr_seq_ctrl
  import sr_seq_pkg::*;
#(
  parameter int ADDR_W        = 13,
  parameter int SEQ_LEN       = 6,
  // Entry 0 (the first address of the sequence) sits in the lowest ADDR_W bits
  parameter logic [(SEQ_LEN-1)*ADDR_W-1:0] PREFIX =
    {13'h00FF, 13'h1CCC, 13'h0333, 13'h15AA, 13'h0A55},
  parameter logic [ADDR_W-1:0] STORE_CODE  = 13'h1F00,
  parameter logic [ADDR_W-1:0] RECALL_CODE = 13'h0E0E,
  parameter int STORE_CYCLES  = 500000,
  parameter int RECALL_CYCLES = 1000,
  localparam int STEP_W = $clog2(SEQ_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              vcc_ok,
  output logic              busy,
  output logic              store_start,
  output logic              recall_start,
  output logic              op_done,
  output logic              op_aborted
);

  seqStrobe_t        stb;
  seqStatus_t        stat;
  logic [STEP_W-1:0] seqStep;

  sr_seq_dp #(
    .ADDR_W(ADDR_W), .SEQ_LEN(SEQ_LEN), .PREFIX(PREFIX),
    .STORE_CODE(STORE_CODE), .RECALL_CODE(RECALL_CODE),
    .STORE_CYCLES(STORE_CYCLES), .RECALL_CYCLES(RECALL_CYCLES)
  ) uDp (
    .clk(clk), .rst_n(rst_n), .ceN(ce_n), .weN(we_n), .addr(addr),
    .vccOk(vcc_ok), .stb(stb), .stat(stat), .seqStep(seqStep)
  );

  sr_seq_fsm uFsm (
    .clk(clk), .rst_n(rst_n), .vccOk(vcc_ok), .stat(stat), .stb(stb),
    .busy(busy), .storeStart(store_start), .recallStart(recall_start),
    .opDone(op_done), .opAborted(op_aborted)
  );

endmodule

// File: rtl/sr_seq_ctrl_chk.sv
module sr_seq_ctrl_chk #(
  parameter int STORE_CYCLES  = 500000,
  parameter int RECALL_CYCLES = 1000,
  parameter int STEP_W        = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              oe_n,
  input logic              vcc_ok,
  input logic              busy,
  input logic              store_start,
  input logic              recall_start,
  input logic              op_done,
  input logic              op_aborted,
  input logic [STEP_W-1:0] seqStep,
  input logic              rdEvt,
  input logic              vccRise,
  input logic              addrIsFirst,
  input logic              atFinal
);

  logic storeRun;
  int   busyLen;
  logic curStore;

  assign curStore = store_start || (storeRun && !recall_start);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      storeRun <= 1'b0;
      busyLen  <= 0;
    end else begin
      if (store_start)       storeRun <= 1'b1;
      else if (recall_start) storeRun <= 1'b0;
      if (store_start || recall_start) busyLen <= 1;
      else if (busy)                   busyLen <= busyLen + 1;
    end
  end

  a_r12_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({store_start, recall_start, op_done, op_aborted}));

  a_r7_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (store_start || recall_start) |-> busy);

  a_r7_rise_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (store_start || recall_start));

  a_r7_done_len: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |-> (!busy && busyLen == (storeRun ? STORE_CYCLES : RECALL_CYCLES)));

  a_r9_store_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && curStore && !vcc_ok) |=> (op_aborted && !busy));

  a_r10_recall_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !curStore) |=> !op_aborted);

  a_r11_rise_recall: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && vccRise) |=> (recall_start && busy));

  a_r8_busy_seq_empty: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (seqStep == '0));

  a_r3_first_oe_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && vcc_ok && !vccRise && rdEvt && addrIsFirst && !atFinal && oe_n)
      |=> (seqStep == STEP_W'(1)));

  a_r3_first_oe_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && vcc_ok && !vccRise && rdEvt && addrIsFirst && !atFinal && !oe_n)
      |=> (seqStep == STEP_W'(1)));

endmodule

bind sr_seq_ctrl sr_seq_ctrl_chk #(
  .STORE_CYCLES(STORE_CYCLES), .RECALL_CYCLES(RECALL_CYCLES), .STEP_W(STEP_W)
) uChk (
  .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .vcc_ok(vcc_ok), .busy(busy),
  .store_start(store_start), .recall_start(recall_start),
  .op_done(op_done), .op_aborted(op_aborted), .seqStep(seqStep),
  .rdEvt(stat.rdEvt), .vccRise(stat.vccRise),
  .addrIsFirst(stat.addrIsFirst), .atFinal(stat.atFinal)
);

// File: tb/sr_seq_ctrl_test.sv
module sr_seq_ctrl_test;
  localparam int AW = 13;
  localparam int SC = 40;
  localparam int RC = 12;
  localparam logic [AW-1:0] K0 = 13'h0A55, K1 = 13'h15AA, K2 = 13'h0333,
                            K3 = 13'h1CCC, K4 = 13'h00FF,
                            KS = 13'h1F00, KR = 13'h0E0E;

  logic clk = 1'b0, rst_n = 1'b0, ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, vcc_ok = 1'b0;
  logic [AW-1:0] addr = '0;
  logic busy, store_start, recall_start, op_done, op_aborted;

  sr_seq_ctrl #(
    .ADDR_W(AW), .SEQ_LEN(6), .PREFIX({K4, K3, K2, K1, K0}),
    .STORE_CODE(KS), .RECALL_CODE(KR),
    .STORE_CYCLES(SC), .RECALL_CYCLES(RC)
  ) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .vcc_ok(vcc_ok), .busy(busy), .store_start(store_start),
    .recall_start(recall_start), .op_done(op_done), .op_aborted(op_aborted)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int nStore = 0, nRecall = 0, nDone = 0, nAbort = 0, nOverlap = 0;
  bit finished = 0;

  // behavioural reference
  int mStep, mRem;
  bit mBusy, mStoreRun, mCePrev, mVccPrev;
  bit eSS, eRS, eDone, eAbt;
  bit rdE, wrE, riseE;

  function automatic logic [AW-1:0] keyAt(int i);
    case (i)
      0: return K0; 1: return K1; 2: return K2; 3: return K3; default: return K4;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mStep = 0; mRem = 0; mBusy = 0; mStoreRun = 0; mCePrev = 1; mVccPrev = 0;
      eSS = 0; eRS = 0; eDone = 0; eAbt = 0;
    end else begin
      rdE = mCePrev && !ce_n && we_n;
      wrE = !ce_n && !we_n;
      riseE = vcc_ok && !mVccPrev;
      eSS = 0; eRS = 0; eDone = 0; eAbt = 0;
      if (mBusy) begin
        if (mStoreRun && !vcc_ok) begin mBusy = 0; eAbt = 1; end
        else if (mRem == 1) begin mBusy = 0; eDone = 1; end
        else mRem--;
      end else if (riseE) begin
        mBusy = 1; mStoreRun = 0; mRem = RC; eRS = 1; mStep = 0;
      end else if (!vcc_ok || wrE) begin
        mStep = 0;
      end else if (rdE) begin
        if (mStep == 5) begin
          mStep = 0;
          if (addr == KS) begin mBusy = 1; mStoreRun = 1; mRem = SC; eSS = 1; end
          else if (addr == KR) begin mBusy = 1; mStoreRun = 0; mRem = RC; eRS = 1; end
          else if (addr == K0) mStep = 1;
        end else if (addr == keyAt(mStep)) mStep++;
        else if (addr == K0) mStep = 1;
        else mStep = 0;
      end
      mCePrev = ce_n; mVccPrev = vcc_ok;
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finishUp();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // per-cycle comparison and pulse counting
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      check(busy == mBusy, "R7 busy", busy, mBusy);
      check(store_start == eSS, "R5 store_start", store_start, eSS);
      check(recall_start == eRS, "R11 recall_start", recall_start, eRS);
      check(op_done == eDone, "R7 op_done", op_done, eDone);
      check(op_aborted == eAbt, "R9 op_aborted", op_aborted, eAbt);
      nStore += store_start; nRecall += recall_start;
      nDone += op_done; nAbort += op_aborted;
      if ((store_start + recall_start + op_done + op_aborted) > 1) nOverlap++;
    end
    if (cyc > 20000) begin
      check(0, "watchdog", cyc, 20000);
      finishUp();
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(logic [AW-1:0] a, logic oe = 1'b1);
    @(negedge clk); ce_n = 0; we_n = 1; addr = a; oe_n = oe;
    @(negedge clk); ce_n = 1;
  endtask

  task automatic wr(logic [AW-1:0] a);
    @(negedge clk); ce_n = 0; we_n = 0; addr = a;
    @(negedge clk); ce_n = 1; we_n = 1;
  endtask

  task automatic knock(logic [AW-1:0] last);
    rd(K0); rd(K1); rd(K2); rd(K3); rd(K4); rd(last);
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (busy) @(negedge clk);
    idle(2);
  endtask

  initial begin
    int s0, r0, d0, a0;
    idle(3);
    check(!busy && !store_start && !recall_start && !op_done && !op_aborted,
          "R1 reset outputs", busy, 0);
    rst_n = 1;
    idle(3);
    check(busy == 0 && nRecall == 0, "R1 idle after reset", nRecall, 0);

    knock(KS); idle(2);
    check(nStore == 0, "R11 knock ignored with supply low", nStore, 0);

    vcc_ok = 1; idle(2);
    check(nRecall == 1 && busy, "R11 power-up recall", nRecall, 1);
    waitIdle();
    check(nDone == 1, "R7 recall done", nDone, 1);

    rd(K0, 0); rd(K1, 1); rd(K2, 0); rd(K3, 0); rd(K4, 1); rd(KS, 0); idle(2);
    check(nStore == 1, "R3 R5 store knock with oe_n mixed", nStore, 1);
    waitIdle();
    check(nDone == 2, "R7 store done", nDone, 2);

    knock(KR); idle(2);
    check(nRecall == 2, "R5 recall knock", nRecall, 2);
    waitIdle();

    s0 = nStore; r0 = nRecall;
    knock(13'h0001); idle(2);
    check(nStore == s0 && nRecall == r0, "R6 unknown final code", nStore + nRecall, s0 + r0);

    rd(K0); rd(K1); rd(K0); rd(K1); rd(K2); rd(K3); rd(K4); rd(KS); idle(2);
    check(nStore == s0 + 1, "R6 restart on first address", nStore, s0 + 1);
    waitIdle();

    s0 = nStore;
    rd(K0); rd(K1); rd(K1); rd(K2); rd(K3); rd(K4); rd(KS); idle(2);
    check(nStore == s0, "R6 repeated read breaks sequence", nStore, s0);

    rd(K0); rd(K1); rd(K2); wr(K3); rd(K3); rd(K4); rd(KS); idle(2);
    check(nStore == s0, "R4 write clears sequence", nStore, s0);

    @(negedge clk); ce_n = 0; we_n = 1; addr = K0;
    @(negedge clk); addr = K1; @(negedge clk); addr = K2;
    @(negedge clk); addr = K3; @(negedge clk); addr = K4;
    @(negedge clk); addr = KS; @(negedge clk); ce_n = 1; idle(2);
    check(nStore == s0, "R2 held chip enable counts once", nStore, s0);

    knock(KS); idle(1);
    r0 = nRecall; d0 = nDone;
    knock(KR);
    waitIdle();
    check(nRecall == r0 && nDone == d0 + 1, "R8 knock ignored while busy", nRecall, r0);
    rd(KR); idle(2);
    check(nRecall == r0, "R8 no leftover sequence", nRecall, r0);

    knock(KS); idle(5);
    d0 = nDone; a0 = nAbort;
    vcc_ok = 0; idle(3);
    check(nAbort == a0 + 1 && !busy, "R9 store aborted", nAbort, a0 + 1);
    check(nDone == d0, "R9 no done after abort", nDone, d0);
    r0 = nRecall;
    vcc_ok = 1; idle(2);
    check(nRecall == r0 + 1, "R11 recall on supply return", nRecall, r0 + 1);
    waitIdle();

    knock(KR); idle(2);
    d0 = nDone; a0 = nAbort; r0 = nRecall;
    vcc_ok = 0; idle(3); vcc_ok = 1;
    waitIdle(); idle(2);
    check(nDone == d0 + 1 && nAbort == a0, "R10 recall survives low supply", nAbort, a0);
    check(nRecall == r0, "R10 rise during recall ignored", nRecall, r0);

    check(nOverlap == 0, "R12 pulses exclusive", nOverlap, 0);
    finishUp();
  end
endmodule